// File: doc/BRIEF.md
# Radix-4 Recoded Partial-Product Row Unit

This combinational unit forms one row of a radix-4 multiplier. It looks at two adjacent multiplier bits plus the bit just below them. It recodes that window into a signed digit from -2 to +2, and it builds the matching multiple of the multiplicand. No adder is used. Doubling is a one-place left shift through a per-bit mux. Negation is a bitwise inversion plus a carry-in bit, which the downstream accumulator adds in the row's least significant column. A zero digit clears the row.

The digit leaves the unit as three control wires: invert, double and clear. The row is one bit wider than the multiplicand so that a doubled value fits. A mode input picks the value of the bit above the multiplicand. When the mode is set, that bit copies the multiplicand's top bit (two's-complement operand). When the mode is clear, it is 0 (unsigned operand). A separate sign output gives the row's sign for the sign-extension scheme used by the accumulator.

The instance that handles the lowest digit of the multiplier is built with `FIRST_DIGIT = 1`. That instance uses 0 for the window's lowest bit, whatever is on `mplier_below`.

Top module: `booth_row_unit`

## Requirements
- R1: The window (hi, mid, lo) = (`mplier_pair[1]`, `mplier_pair[0]`, below bit) recodes as 000→0, 001→+1, 010→+1, 011→+2, 100→-2, 101→-1, 110→-1, 111→0. `ctl_zero` is 1 exactly when the digit is 0.
- R2: For every nonzero digit, `ctl_comp` equals the window's hi bit, so it is 1 exactly for negative digits.
- R3: For every nonzero digit, `ctl_shift` is 1 exactly when the digit magnitude is 2, that is when mid equals lo.
- R4: Let ext be `signed_mode & mcand[A_W-1]`. Then the signed value of {`row_sign`, `row_bits`} plus `row_cin` equals the digit times the multiplicand. The multiplicand is read as two's complement when `signed_mode` is 1 and as unsigned otherwise.
- R5: For a zero digit, `row_bits`, `row_cin` and `row_sign` are all 0.
- R6: For a nonzero digit, `row_cin` equals `ctl_comp`.
- R7: With `FIRST_DIGIT = 1`, the below bit is taken as 0. A 1 on `mplier_below` then has no effect on any output.
- R8: For a digit of magnitude 1, the top row bit `row_bits[A_W]` equals ext XOR `ctl_comp`.
- R9: For a nonzero digit, `row_sign` equals ext XOR `ctl_comp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand | input | A_W | Multiplicand |
| mplier_pair | input | 2 | Multiplier bits of this digit, [1] is the higher |
| mplier_below | input | 1 | Multiplier bit just below the pair |
| signed_mode | input | 1 | 1: multiplicand is two's complement; 0: unsigned |
| row_bits | output | A_W+1 | Row bits before the carry-in |
| row_cin | output | 1 | Carry-in that completes negation |
| row_sign | output | 1 | Sign of the row for sign extension |
| ctl_comp | output | 1 | Invert control (digit negative) |
| ctl_shift | output | 1 | Double control (digit magnitude 2) |
| ctl_zero | output | 1 | Clear control (digit zero) |

## Verification
The hardest case is a negative digit applied to a zero or extreme multiplicand. With a zero multiplicand the inverted row is all ones, and only the carry-in and the sign bit bring the value back to zero. With 0x80 in two's-complement mode, doubling moves the sign bit into the top row position. The bench therefore sweeps every window in a vector table. For each window it applies 0, 0x7F, 0x80, 0xFF and patterned and random multiplicands in both modes. It then rebuilds the row's value from the outputs and compares it with the digit times the operand. A second instance, built as the lowest digit, gets a 1 on its below input so that the forced-zero rule shows up in its outputs.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef struct packed {
        logic comp;
        logic shift;
        logic zero;
    } booth_ctl_t;

    // Signed value of a recoded window, written as a table for cross-checks.
    function automatic logic signed [2:0] booth_digit(input logic [2:0] win);
        case (win)
            3'b001, 3'b010: booth_digit = 3'sd1;
            3'b011:         booth_digit = 3'sd2;
            3'b100:         booth_digit = -3'sd2;
            3'b101, 3'b110: booth_digit = -3'sd1;
            default:        booth_digit = 3'sd0;
        endcase
    endfunction

endpackage

// File: rtl/booth_window.sv
module booth_window #(
    parameter bit FIRST_DIGIT = 1'b0
) (
    input  logic [1:0] pair,
    input  logic       below,
    output logic [2:0] win
);
    logic lo_bit;

    assign lo_bit = FIRST_DIGIT ? 1'b0 : below;
    assign win    = {pair, lo_bit};

    always_comb begin
        if (FIRST_DIGIT)
            assert_first_low_R7: assert (win[0] == 1'b0 || $isunknown(win))
                else $error("R7 window low bit not forced");
    end
endmodule

// File: rtl/booth_digit_enc.sv
module booth_digit_enc
    import booth_pkg::*;
(
    input  logic [2:0]  win,
    output booth_ctl_t  ctl
);
    always_comb begin
        ctl.zero  = (win[2] & win[1] & win[0]) | ~(win[2] | win[1] | win[0]);
        ctl.comp  = win[2];
        ctl.shift = ~(win[1] ^ win[0]);
    end

    always_comb begin
        if (!$isunknown(win)) begin
            assert_zero_digit_R1: assert (ctl.zero == (booth_digit(win) == 3'sd0))
                else $error("R1 zero control mismatch");
            if (!ctl.zero) begin
                assert_comp_neg_R2: assert (ctl.comp == booth_digit(win)[2])
                    else $error("R2 invert control mismatch");
                assert_shift_mag2_R3: assert (ctl.shift ==
                        (booth_digit(win) == 3'sd2 || booth_digit(win) == -3'sd2))
                    else $error("R3 double control mismatch");
            end
        end
    end
endmodule

// File: rtl/booth_row_gen.sv
module booth_row_gen
    import booth_pkg::*;
#(
    parameter int A_W = 8
) (
    input  logic [A_W-1:0] mcand,
    input  logic           signed_mode,
    input  booth_ctl_t     ctl,
    output logic [A_W:0]   row,
    output logic           cin,
    output logic           sign
);
    logic ext;

    assign ext = signed_mode & mcand[A_W-1];

    for (genvar j = 0; j <= A_W; j++) begin : g_bit
        logic here, lower, pick;
        if (j == A_W) begin : g_top
            assign here = ext;
        end else begin : g_body
            assign here = mcand[j];
        end
        if (j == 0) begin : g_lsb
            assign lower = 1'b0;
        end else begin : g_up
            assign lower = mcand[j-1];
        end
        assign pick   = ctl.shift ? lower : here;
        assign row[j] = ~ctl.zero & (pick ^ ctl.comp);
    end

    assign cin  = ctl.comp & ~ctl.zero;
    assign sign = ~ctl.zero & (ext ^ ctl.comp);

    always_comb begin
        if (!$isunknown({ctl, mcand, signed_mode})) begin
            if (ctl.zero)
                assert_zero_row_R5: assert (row == '0 && !cin && !sign)
                    else $error("R5 zero row not clear");
            else begin
                assert_top_bit_R8: assert (ctl.shift ||
                        row[A_W] == ((signed_mode & mcand[A_W-1]) ^ ctl.comp))
                    else $error("R8 top row bit wrong");
                assert_sign_R9: assert (sign == ((signed_mode & mcand[A_W-1]) ^ ctl.comp))
                    else $error("R9 sign bit wrong");
            end
        end
    end
endmodule

// File: rtl/booth_row_unit.sv
module booth_row_unit
    import booth_pkg::*;
#(
    parameter int A_W         = 8,
    parameter bit FIRST_DIGIT = 1'b0
) (
    input  logic [A_W-1:0] mcand,
    input  logic [1:0]     mplier_pair,
    input  logic           mplier_below,
    input  logic           signed_mode,
    output logic [A_W:0]   row_bits,
    output logic           row_cin,
    output logic           row_sign,
    output logic           ctl_comp,
    output logic           ctl_shift,
    output logic           ctl_zero
);
    localparam int PW = A_W + 3;

    logic [2:0] win;
    booth_ctl_t ctl;

    booth_window #(.FIRST_DIGIT(FIRST_DIGIT)) u_win (
        .pair  (mplier_pair),
        .below (mplier_below),
        .win   (win)
    );

    booth_digit_enc u_enc (
        .win (win),
        .ctl (ctl)
    );

    booth_row_gen #(.A_W(A_W)) u_row (
        .mcand       (mcand),
        .signed_mode (signed_mode),
        .ctl         (ctl),
        .row         (row_bits),
        .cin         (row_cin),
        .sign        (row_sign)
    );

    assign ctl_comp  = ctl.comp;
    assign ctl_shift = ctl.shift;
    assign ctl_zero  = ctl.zero;

    logic signed [PW-1:0] val_got, val_want, opnd, dig_x;
    logic signed [2:0]    dig;

    always_comb begin
        dig      = booth_digit(win);
        dig_x    = $signed({{(PW-3){dig[2]}}, dig});
        opnd     = $signed({{3{signed_mode & mcand[A_W-1]}}, mcand});
        val_want = opnd * dig_x;
        val_got  = $signed({row_sign, row_sign, row_bits}) + $signed({{(PW-1){1'b0}}, row_cin});
    end

    always_comb begin
        if (!$isunknown({win, mcand, signed_mode})) begin
            assert_row_value_R4: assert (val_got == val_want)
                else $error("R4 row value mismatch");
            if (!ctl_zero)
                assert_cin_comp_R6: assert (row_cin == ctl_comp)
                    else $error("R6 carry-in mismatch");
        end
    end
endmodule

// File: tb/booth_row_unit_tb.sv
module booth_row_unit_tb;
    localparam int A_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [A_W-1:0] mcand = '0;
    logic [1:0]     pair  = '0;
    logic           below = 1'b0;
    logic           smode = 1'b0;

    logic [A_W:0] r_bits, f_bits;
    logic r_cin, r_sign, r_comp, r_shift, r_zero;
    logic f_cin, f_sign, f_comp, f_shift, f_zero;

    booth_row_unit #(.A_W(A_W), .FIRST_DIGIT(1'b0)) u_dut (
        .mcand(mcand), .mplier_pair(pair), .mplier_below(below), .signed_mode(smode),
        .row_bits(r_bits), .row_cin(r_cin), .row_sign(r_sign),
        .ctl_comp(r_comp), .ctl_shift(r_shift), .ctl_zero(r_zero)
    );

    booth_row_unit #(.A_W(A_W), .FIRST_DIGIT(1'b1)) u_dut_first (
        .mcand(mcand), .mplier_pair(pair), .mplier_below(below), .signed_mode(smode),
        .row_bits(f_bits), .row_cin(f_cin), .row_sign(f_sign),
        .ctl_comp(f_comp), .ctl_shift(f_shift), .ctl_zero(f_zero)
    );

    // [8:6] window, [5:3] digit, [2] comp, [1] shift, [0] zero
    localparam logic [8:0] VEC [8] = '{
        9'b000_000_0_0_1, 9'b001_001_0_0_0, 9'b010_001_0_0_0, 9'b011_010_0_1_0,
        9'b100_110_1_1_0, 9'b101_111_1_0_0, 9'b110_111_1_0_0, 9'b111_000_0_0_1
    };
    localparam logic [7:0] MC [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h55};

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int row_val(input logic s, input logic [A_W:0] b, input logic c);
        return (s ? -(1 << (A_W + 1)) : 0) + int'(b) + int'(c);
    endfunction

    function automatic int opnd_val(input logic [A_W-1:0] a, input logic sm);
        return (sm && a[A_W-1]) ? int'(a) - (1 << A_W) : int'(a);
    endfunction

    task automatic apply_and_check(input logic [8:0] v, input logic [A_W-1:0] a, input logic sm);
        int dig, want, got;
        logic ext;
        @(posedge clk);
        pair  = v[8:7];
        below = v[6];
        mcand = a;
        smode = sm;
        @(negedge clk);
        dig  = $signed(v[5:3]);
        want = dig * opnd_val(a, sm);
        got  = row_val(r_sign, r_bits, r_cin);
        ext  = sm & a[A_W-1];
        check(got == want, "R4 row value", got, want);
        check(r_zero == v[0], "R1 zero control", int'(r_zero), int'(v[0]));
        if (v[0]) begin
            check(r_bits == '0 && !r_cin && !r_sign, "R5 zero row clear",
                  int'({r_sign, r_cin, r_bits}), 0);
        end else begin
            check(r_comp == v[2], "R2 invert control", int'(r_comp), int'(v[2]));
            check(r_shift == v[1], "R3 double control", int'(r_shift), int'(v[1]));
            check(r_cin == v[2], "R6 carry-in", int'(r_cin), int'(v[2]));
            check(r_sign == (ext ^ v[2]), "R9 sign bit", int'(r_sign), int'(ext ^ v[2]));
            if (!v[1])
                check(r_bits[A_W] == (ext ^ v[2]), "R8 top row bit",
                      int'(r_bits[A_W]), int'(ext ^ v[2]));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state: all inputs low gives an empty row
        check(r_bits == '0 && !r_cin && !r_sign && r_zero, "R5 reset idle row",
              int'({r_sign, r_cin, r_bits}), 0);

        // Vector table walk: every window, fixed and random multiplicands, both modes
        for (int i = 0; i < 8; i++) begin
            for (int m = 0; m < 2; m++) begin
                for (int k = 0; k < 6; k++)
                    apply_and_check(VEC[i], MC[k], m[0]);
                for (int k = 0; k < 10; k++)
                    apply_and_check(VEC[i], A_W'($urandom), m[0]);
            end
        end

        // R7: lowest-digit instance ignores a 1 on the below input
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 2; m++) begin
                int dig, want, got;
                @(posedge clk);
                pair  = p[1:0];
                below = 1'b1;
                mcand = 8'hB3;
                smode = m[0];
                @(negedge clk);
                case (p)
                    1: dig = 1;
                    2: dig = -2;
                    3: dig = -1;
                    default: dig = 0;
                endcase
                want = dig * opnd_val(8'hB3, m[0]);
                got  = row_val(f_sign, f_bits, f_cin);
                check(got == want, "R7 first digit value", got, want);
                check(f_zero == (p == 0), "R7 first digit zero", int'(f_zero), int'(p == 0));
            end
        end

        // Corner: zero operand with negative digit gives all ones plus carry
        apply_and_check(VEC[5], 8'h00, 1'b1);
        @(negedge clk);
        check(r_bits == '1 && r_cin, "R4 inverted zero row", int'(r_bits), (1 << (A_W + 1)) - 1);
        // Corner: most negative operand doubled and negated
        apply_and_check(VEC[4], 8'h80, 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                if (!done) check(1'b0, "watchdog expired", 0, 1);
            end
            wait (done);
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule